// File: doc/BRIEF.md
# Double-Data-Rate Nibble Link with Side-Lane Backpressure

This block carries a byte stream one way between two chips over a narrow 4-bit port that moves a nibble on each clock edge, so one byte crosses per clock. At an 80 MHz port clock that is 80 MByte/s. The sending half takes bytes on a valid/ready stream. It splits each byte into a rising-edge nibble and a falling-edge nibble, and sends a frame qualifier with them. The receiving half captures both nibbles, puts the byte back together and stores it in a small buffer. The buffer drains through a second valid/ready stream.

Backpressure does not use the data port. The receiver drives a set of side lanes back to the sender. Each lane is refreshed at a divided rate: with two lanes, every lane runs at half the port clock. The lanes take turns, so a new hold request reaches the wire on the next edge. The sender stops as soon as any lane is high. The receiver raises hold while it still has enough free entries to absorb every byte already in flight.

The pad primitives are modelled as ideal registers. The data port therefore appears as the pair of nibbles that one clock period carries. The sending and receiving port groups are brought out separately, so the two halves can sit in different chips and be wired across a board.

Top module: `ddrl_link`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_valid` is 0, `tx_frame_o` is 0, `rx_hold_o` is all zero and `in_ready` is 1.
- R2: A byte accepted on a rising edge (`in_valid` and `in_ready` both 1) drives `tx_frame_o` to 1 after that edge. With HI_FIRST=1, `tx_rise_o` carries byte bits 7:4 and `tx_fall_o` carries bits 3:0. With HI_FIRST=0 the two nibbles are swapped.
- R3: After any edge that accepts no byte, `tx_frame_o` is 0 and both transmit nibbles are 0.
- R4: A beat that has `rx_frame_i` at 1 when sampled on edge k is written to the buffer on edge k+1. Taken end to end, a byte accepted into an empty link on edge a appears on `out_data` with `out_valid` high after edge a+2, and not before.
- R5: While `rx_frame_i` is 0, the receive nibbles are ignored. Whatever they carry, no byte enters the buffer.
- R6: When the buffer holds DEPTH-HOLD_MARGIN or more bytes, at least one lane of `rx_hold_o` is high after the next edge. Lane k changes only on edges where a rotating phase counter (0 to SIDE_LANES-1, starting at 0 after reset) equals k. Once the buffer is below the threshold, all lanes are low within SIDE_LANES edges.
- R7: A high lane on `tx_hold_i` sampled on an edge drives `in_ready` to 0 after the next edge. A lane that stays high for two consecutive sampled edges holds `tx_frame_o` at 0 after the edge that follows.
- R8: With HOLD_MARGIN of at least 4, the buffer is never written while it is full, and no byte is dropped even while `out_ready` stays low.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value on the next cycle.
- R10: Every accepted byte leaves `out_data` exactly once, unchanged and in acceptance order, under random sink stalls and random holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock shared by both halves |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Send stream valid |
| in_ready | output | 1 | Send stream ready; low while a hold is registered |
| tx_rise_o | output | 4 | Nibble carried on the rising clock edge |
| tx_fall_o | output | 4 | Nibble carried on the falling clock edge |
| tx_frame_o | output | 1 | Qualifier; high when the nibble pair is a byte |
| tx_hold_i | input | SIDE_LANES | Backpressure lanes arriving at the sender |
| rx_rise_i | input | 4 | Rising-edge nibble arriving at the receiver |
| rx_fall_i | input | 4 | Falling-edge nibble arriving at the receiver |
| rx_frame_i | input | 1 | Qualifier arriving at the receiver |
| rx_hold_o | output | SIDE_LANES | Backpressure lanes leaving the receiver |
| out_data | output | 8 | Rebuilt byte at the head of the buffer |
| out_valid | output | 1 | Buffer not empty |
| out_ready | input | 1 | Sink takes the head byte on this edge |

## Verification
The bench builds the link with DEPTH=8, HOLD_MARGIN=4, SIDE_LANES=2 and HI_FIRST=1. Hold therefore rises at half occupancy, and the four bytes already in flight bring the buffer right up to full. A short stall of the sink is enough to reach the edge where overflow would happen, and the in-flight count has no slack to hide behind. Two lanes make the rotating refresh and the lagging release both visible within a few cycles. The bench also drives junk onto the receive nibbles while the qualifier is low, forces holds from outside the receiver, and checks the nibble order, so each timing rule is observed at the pins.

// File: rtl/ddrl_pkg.sv
package ddrl_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // One clock period of the port: the nibble pair plus its qualifier.
    typedef struct packed {
        logic frame;
        nib_t rise;
        nib_t fall;
    } beat_t;

    localparam beat_t IDLE_BEAT = '0;

    function automatic beat_t split_byte(input byte_t b, input bit hi_first);
        beat_t r;
        r.frame = 1'b1;
        if (hi_first) begin
            r.rise = b[BYTE_W-1:NIB_W];
            r.fall = b[NIB_W-1:0];
        end else begin
            r.rise = b[NIB_W-1:0];
            r.fall = b[BYTE_W-1:NIB_W];
        end
        return r;
    endfunction

    function automatic byte_t merge_beat(input beat_t x, input bit hi_first);
        return hi_first ? {x.rise, x.fall} : {x.fall, x.rise};
    endfunction

endpackage

// File: rtl/ddrl_tx.sv
module ddrl_tx
    import ddrl_pkg::*;
#(
    parameter int LANES    = 2,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_t            in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] hold_i,
    output beat_t            beat_o
);

    logic [LANES-1:0] hold_q;
    logic             take;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_i;
    end

    assign in_ready = ~|hold_q;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)       beat_o <= IDLE_BEAT;
        else if (take) beat_o <= split_byte(in_data, HI_FIRST);
        else           beat_o <= IDLE_BEAT;
    end

    // R2
    launch_frame_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> beat_o.frame);

    // R3
    idle_beat_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> beat_o == IDLE_BEAT);

    // R7
    hold_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (|hold_i) |=> !in_ready);

    // R7
    hold_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (|hold_i) && $past(|hold_i) |=> !beat_o.frame);

endmodule

// File: rtl/ddrl_side.sv
module ddrl_side #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_req,
    output logic [LANES-1:0] lanes_o
);

    localparam int PH_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                             phase <= '0;
        else if (phase == PH_W'(LANES - 1))  phase <= '0;
        else                                 phase <= phase + 1'b1;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)                      lanes_o[k] <= 1'b0;
            else if (phase == PH_W'(k))   lanes_o[k] <= hold_req;
        end

        // R6
        lane_slot_chk: assert property (@(posedge clk) disable iff (rst)
            lanes_o[k] != $past(lanes_o[k]) |-> $past(phase) == PH_W'(k));
    end

    // R6
    hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
        hold_req |=> |lanes_o);

endmodule

// File: rtl/ddrl_fifo.sv
module ddrl_fifo
    import ddrl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  byte_t                      wr_data,
    input  logic                       rd_en,
    output byte_t                      rd_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    byte_t         mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_rd;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign rd_data = mem[rp];
    assign do_rd   = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_en, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !empty && !rd_en |=> !empty && $stable(rd_data));

endmodule

// File: rtl/ddrl_rx.sv
module ddrl_rx
    import ddrl_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int HOLD_MARGIN = 4,
    parameter int LANES       = 2,
    parameter bit HI_FIRST    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat_i,
    output logic [LANES-1:0] hold_o,
    output byte_t            out_data,
    output logic             out_valid,
    input  logic             out_ready
);

    localparam int CW       = $clog2(DEPTH + 1);
    localparam int HOLD_AT  = DEPTH - HOLD_MARGIN;
    localparam logic [CW-1:0] HOLD_LVL = CW'(HOLD_AT);

    beat_t         cap_q;
    logic          empty, full, hold_req;
    logic [CW-1:0] level;

    // Ideal capture of both edge phases.
    always_ff @(posedge clk) begin
        if (rst) cap_q <= IDLE_BEAT;
        else     cap_q <= beat_i;
    end

    ddrl_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cap_q.frame),
        .wr_data(merge_beat(cap_q, HI_FIRST)),
        .rd_en  (out_ready),
        .rd_data(out_data),
        .empty  (empty),
        .full   (full),
        .level  (level)
    );

    assign out_valid = !empty;
    assign hold_req  = (level >= HOLD_LVL);

    ddrl_side #(.LANES(LANES)) u_side (
        .clk     (clk),
        .rst     (rst),
        .hold_req(hold_req),
        .lanes_o (hold_o)
    );

    // R4
    rx_latency_chk: assert property (@(posedge clk) disable iff (rst)
        beat_i.frame |=> ##1 out_valid);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> hold_req);

endmodule

// File: rtl/ddrl_link.sv
module ddrl_link
    import ddrl_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int HOLD_MARGIN = 4,
    parameter int SIDE_LANES  = 2,
    parameter bit HI_FIRST    = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            in_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    output logic [3:0]            tx_rise_o,
    output logic [3:0]            tx_fall_o,
    output logic                  tx_frame_o,
    input  logic [SIDE_LANES-1:0] tx_hold_i,
    input  logic [3:0]            rx_rise_i,
    input  logic [3:0]            rx_fall_i,
    input  logic                  rx_frame_i,
    output logic [SIDE_LANES-1:0] rx_hold_o,
    output logic [7:0]            out_data,
    output logic                  out_valid,
    input  logic                  out_ready
);

    beat_t tx_beat, rx_beat;

    ddrl_tx #(.LANES(SIDE_LANES), .HI_FIRST(HI_FIRST)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .in_data (in_data),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .hold_i  (tx_hold_i),
        .beat_o  (tx_beat)
    );

    assign tx_rise_o  = tx_beat.rise;
    assign tx_fall_o  = tx_beat.fall;
    assign tx_frame_o = tx_beat.frame;

    assign rx_beat.frame = rx_frame_i;
    assign rx_beat.rise  = rx_rise_i;
    assign rx_beat.fall  = rx_fall_i;

    ddrl_rx #(
        .DEPTH      (DEPTH),
        .HOLD_MARGIN(HOLD_MARGIN),
        .LANES      (SIDE_LANES),
        .HI_FIRST   (HI_FIRST)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .beat_i   (rx_beat),
        .hold_o   (rx_hold_o),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_ready(out_ready)
    );

endmodule

// File: tb/ddrl_link_test.sv
module ddrl_link_test;
    import ddrl_pkg::*;

    localparam int DEPTH  = 8;
    localparam int MARGIN = 4;
    localparam int LANES  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [3:0]       tx_rise, tx_fall, rx_rise, rx_fall;
    logic             tx_frame, rx_frame;
    logic [LANES-1:0] tx_hold, rx_hold;
    logic [7:0]       out_data;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             inject = 1'b0;
    logic             force_hold = 1'b0;
    logic [3:0]       junk_r = '0, junk_f = '0;

    always #2 clk = ~clk;

    assign rx_rise  = inject ? junk_r : tx_rise;
    assign rx_fall  = inject ? junk_f : tx_fall;
    assign rx_frame = tx_frame;
    assign tx_hold  = rx_hold | {LANES{force_hold}};

    ddrl_link #(.DEPTH(DEPTH), .HOLD_MARGIN(MARGIN), .SIDE_LANES(LANES), .HI_FIRST(1'b1)) uut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tx_rise_o(tx_rise), .tx_fall_o(tx_fall), .tx_frame_o(tx_frame), .tx_hold_i(tx_hold),
        .rx_rise_i(rx_rise), .rx_fall_i(rx_fall), .rx_frame_i(rx_frame), .rx_hold_o(rx_hold),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    byte_t sb[$];
    int    rd_mode = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Driver: one negedge per call; accepted bytes enter the scoreboard.
    task automatic drive(input bit v, input byte_t d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        if (v && in_ready) sb.push_back(d);
    endtask

    // Monitor: owns out_ready, pops and compares on each handshake.
    logic  stall_q = 1'b0;
    byte_t stall_d = '0;
    always @(negedge clk) begin
        if (rst) begin
            out_ready = 1'b0;
            stall_q   = 1'b0;
        end else begin
            if (stall_q)
                check(out_valid && out_data == stall_d, "R9 head held during stall",
                      {out_valid, out_data}, {1'b1, stall_d});
            case (rd_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = 1'b0;
                default: out_ready = ($urandom_range(0, 3) != 0);
            endcase
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 byte with none expected", out_data, 0);
                end else begin
                    byte_t e;
                    e = sb.pop_front();
                    check(out_data == e, "R10 byte order and value", out_data, e);
                end
            end
            stall_q = out_valid && !out_ready;
            stall_d = out_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check(out_valid == 0 && tx_frame == 0 && rx_hold == 0 && in_ready == 1,
              "R1 state during reset", {out_valid, tx_frame, rx_hold, in_ready}, 4'b0001);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && tx_frame == 0 && rx_hold == 0 && in_ready == 1,
              "R1 state after reset", {out_valid, tx_frame, rx_hold, in_ready}, 4'b0001);

        // R3 idle port
        drive(0, 8'h00);
        drive(0, 8'h00);
        check(tx_frame == 0 && tx_rise == 0 && tx_fall == 0, "R3 idle beat",
              {tx_frame, tx_rise, tx_fall}, 0);

        // R2 and R4 single byte
        drive(1, 8'hA5);
        drive(0, 8'h00);
        check(tx_frame == 1 && tx_rise == 4'hA && tx_fall == 4'h5, "R2 nibble order A5",
              {tx_frame, tx_rise, tx_fall}, 9'h1A5);
        @(negedge clk);
        check(out_valid == 0, "R4 not yet offered", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1 && out_data == 8'hA5, "R4 offered after two edges",
              {out_valid, out_data}, 9'h1A5);

        drive(1, 8'h3C);
        drive(0, 8'h00);
        check(tx_frame == 1 && tx_rise == 4'h3 && tx_fall == 4'hC, "R2 nibble order 3C",
              {tx_frame, tx_rise, tx_fall}, 9'h13C);
        check(tx_frame == 1, "R2 frame high", tx_frame, 1);
        repeat (4) drive(0, 8'h00);

        // R5 junk nibbles with the qualifier low
        inject = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            junk_r = 4'($urandom);
            junk_f = 4'($urandom);
            check(out_valid == 0, "R5 junk ignored", out_valid, 0);
        end
        inject = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && sb.size() == 0, "R5 nothing stored", out_valid, 0);

        // R7 forced hold with the sender busy
        rd_mode = 1;
        @(negedge clk);
        force_hold = 1'b1;
        in_valid   = 1'b1;
        in_data    = 8'h11;
        if (in_ready) sb.push_back(8'h11);
        @(negedge clk);
        check(in_ready == 0, "R7 ready drops", in_ready, 0);
        @(negedge clk);
        check(tx_frame == 0, "R7 sender stopped", tx_frame, 0);
        repeat (3) @(negedge clk);
        check(tx_frame == 0 && in_ready == 0, "R7 stays stopped", {tx_frame, in_ready}, 0);
        force_hold = 1'b0;

        // R6 and R8 fill against a stalled sink
        for (int i = 0; i < 30; i++) drive(1, byte_t'(8'h40 + i));
        check(rx_hold != 0, "R6 hold raised when filling", rx_hold, 1);
        check(in_ready == 0, "R7 sender held by receiver", in_ready, 0);
        check(sb.size() >= DEPTH - MARGIN && sb.size() <= DEPTH, "R8 buffered count",
              sb.size(), DEPTH);
        drive(0, 8'h00);
        rd_mode = 0;
        for (int i = 0; i < 100 && sb.size() != 0; i++) @(negedge clk);
        check(sb.size() == 0, "R8 all bytes drained", sb.size(), 0);
        repeat (LANES + 1) @(negedge clk);
        check(rx_hold == 0, "R6 hold released", rx_hold, 0);
        check(in_ready == 1, "R7 ready restored", in_ready, 1);

        // R10 random traffic, random sink stalls and random external holds
        rd_mode = 2;
        for (int i = 0; i < 3000; i++) begin
            force_hold = ($urandom_range(0, 7) == 0);
            drive($urandom_range(0, 2) != 0, byte_t'($urandom));
        end
        force_hold = 1'b0;
        drive(0, 8'h00);
        rd_mode = 0;
        for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(sb.size() == 0 && out_valid == 0, "R10 every byte delivered once",
              sb.size(), 0);

        summary();
        $finish;
    end

endmodule